// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block watches one asynchronous non-maskable interrupt wire and reports it to a parent interrupt controller on one registered request line. Software programs a trigger mode (active-low level, falling edge, active-high level or rising edge) in a control word. It acknowledges a captured event by writing a one to a sticky pending flag, and it gates the request with an enable flag. The raw wire is brought into the clock domain by a flop chain before any detection.

The registers sit on a plain 32-bit register bus. A selected write lands on the rising clock edge, and a selected read returns data in the same cycle. The bus never stalls, so there is no back-pressure: every selected access completes in the cycle it is presented. The placement of the three registers in the address space is fixed when the block is built, through a layout parameter with three variants.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control word, pending flag, enable flag and `irq_out` are all zero. The control word therefore starts in active-low level mode, and the synchronizer flops start at logic 1.
- R2: The control register stores all 32 written bits and reads them back unchanged. Its bits [1:0] select the trigger mode: 0 is active-low level, 1 is falling edge, 2 is active-high level and 3 is rising edge.
- R3: In mode 0, the pending flag reads 1 from the third rising clock edge after `nmi_in` goes low, and it is still 0 after the second such edge.
- R4: In mode 2, the pending flag behaves as in R3, with `nmi_in` going high as the active condition.
- R5: In mode 1, one high-to-low transition sets the pending flag once. A flag cleared while the input stays low remains clear. A low-to-high transition does not set it. A one-cycle low pulse is captured.
- R6: In mode 3, the behaviour of R5 applies with the polarities swapped.
- R7: The pending register reports the flag in bit 0 and reads 0 in bits [31:1]. Writing it with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged.
- R8: In a level mode, if a clear is written while the input is at its active level, the set wins and the flag still reads 1.
- R9: The enable register holds bit 0 and reads 0 in its other bits. On each rising edge, `irq_out` takes the AND of the pending and enable flags. Clearing enable does not change the pending flag.
- R10: With LAYOUT 0, the control, pending and enable registers sit at byte offsets 0x00, 0x04 and 0x08. LAYOUT 1 places them at 0x00, 0x04 and 0x34. LAYOUT 2 places them at 0x00, 0x08 and 0x04.
- R11: Reads of any other offset return zero, and writes to any other offset change no register. `reg_rdata` is zero whenever a read is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw asynchronous interrupt wire |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid in the cycle of a selected read |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
The bench builds three copies at the default widths, with LAYOUT set to 0, 1 and 2, all driven from one shared bus. A single write sweep over every word offset from 0x00 to 0x3C is then read back through all three copies. This exposes any offset that one variant decodes wrongly or that aliases onto another register. The copy with the default layout then walks all four trigger modes. In each mode it checks synchronizer latency, held and pulsed input, opposite-polarity transitions, clear-versus-set races and masking of the request line.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'd0,
    TRIG_FALL       = 2'd1,
    TRIG_LEVEL_HIGH = 2'd2,
    TRIG_RISE       = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic [7:0] ctrl_off;
    logic [7:0] pend_off;
    logic [7:0] en_off;
  } reg_map_t;

  // Byte offsets per layout variant; behaviour depends on them.
  function automatic reg_map_t layout_map(input int unsigned layout);
    reg_map_t m;
    case (layout)
      1:       m = '{ctrl_off: 8'h00, pend_off: 8'h04, en_off: 8'h34};
      2:       m = '{ctrl_off: 8'h00, pend_off: 8'h08, en_off: 8'h04};
      default: m = '{ctrl_off: 8'h00, pend_off: 8'h04, en_off: 8'h08};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_line_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  trig_mode_e mode,
  output logic       hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  always_comb begin
    unique case (mode)
      TRIG_LEVEL_LOW:  hit = !lvl;
      TRIG_FALL:       hit = prev_q && !lvl;
      TRIG_LEVEL_HIGH: hit = lvl;
      TRIG_RISE:       hit = !prev_q && lvl;
      default:         hit = 1'b0;
    endcase
  end

  // R5: a falling-edge hit cannot repeat on the very next cycle
  p_fall_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == TRIG_FALL) |=> !(hit && mode == TRIG_FALL));

  // R6: a rising-edge hit cannot repeat on the very next cycle
  p_rise_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == TRIG_RISE) |=> !(hit && mode == TRIG_RISE));

endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hit,
  output trig_mode_e        mode,
  output logic              pend,
  output logic              en
);

  localparam reg_map_t          MAP    = layout_map(LAYOUT);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(MAP.ctrl_off);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(MAP.pend_off);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(MAP.en_off);

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              en_q;
  logic              wr_ok, rd_ok;
  logic              at_ctrl, at_pend, at_en;
  logic              pend_clr;

  assign wr_ok    = reg_sel && reg_we;
  assign rd_ok    = reg_sel && !reg_we;
  assign at_ctrl  = (reg_addr == CTRL_A);
  assign at_pend  = (reg_addr == PEND_A);
  assign at_en    = (reg_addr == EN_A);
  assign pend_clr = wr_ok && at_pend && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl_q <= '0;
    else if (wr_ok && at_ctrl)  ctrl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en_q <= 1'b0;
    else if (wr_ok && at_en)    en_q <= reg_wdata[0];
  end

  // Set from the detector outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= hit || (pend_q && !pend_clr);
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_ok) begin
      if (at_ctrl)      reg_rdata = ctrl_q;
      else if (at_pend) reg_rdata = {{(DATA_W-1){1'b0}}, pend_q};
      else if (at_en)   reg_rdata = {{(DATA_W-1){1'b0}}, en_q};
    end
  end

  assign mode = trig_mode_e'(ctrl_q[1:0]);
  assign pend = pend_q;
  assign en   = en_q;

  // R2: a control write is stored whole
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && at_ctrl) |=> (ctrl_q == $past(reg_wdata)));

  // R7: a clear with no competing event empties the flag
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !hit) |=> !pend_q);

  // R7: without event or clear the flag keeps its value
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !pend_clr) |=> (pend_q == $past(pend_q)));

  // R8: an event always leaves the flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);

  // R11: unmapped reads come back zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !at_ctrl && !at_pend && !at_en) |-> (reg_rdata == '0));

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LAYOUT      = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);

  localparam logic IDLE_LVL = 1'b1;

  logic       nmi_sync;
  logic       hit;
  trig_mode_e mode;
  logic       pend;
  logic       en;
  logic       irq_q;

  nmi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(nmi_sync)
  );

  nmi_trig_detect #(.RST_VAL(IDLE_LVL)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(nmi_sync), .mode(mode), .hit(hit)
  );

  nmi_line_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hit(hit), .mode(mode), .pend(pend), .en(en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend && en;
  end

  assign irq_out = irq_q;

  // R1: request line is quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!irq_out);
  end

  // R3: active-low level reaching the detector sets pending next edge
  p_level_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL_LOW && !nmi_sync) |=> pend);

  // R4: active-high level reaching the detector sets pending next edge
  p_level_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL_HIGH && nmi_sync) |=> pend);

  // R9: masked flag never raises the request
  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_out);

  // R9: enabled pending flag raises the request one edge later
  p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en) |=> irq_out);

endmodule

// File: tb/nmi_line_ctrl_bench.sv
module nmi_line_ctrl_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, nmi, sel, we;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdat [3];
  logic [2:0]    irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  nmi_line_ctrl #(.LAYOUT(0)) u_nmi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi), .reg_sel(sel), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdat[0]), .irq_out(irq[0]));
  nmi_line_ctrl #(.LAYOUT(1)) u_nmi_line_ctrl_l1 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi), .reg_sel(sel), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdat[1]), .irq_out(irq[1]));
  nmi_line_ctrl #(.LAYOUT(2)) u_nmi_line_ctrl_l2 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi), .reg_sel(sel), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdat[2]), .irq_out(irq[2]));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] r0,
                    output logic [31:0] r1, output logic [31:0] r2);
    sel = 1'b1; we = 1'b0; addr = a;
    #2;
    r0 = rdat[0]; r1 = rdat[1]; r2 = rdat[2];
    sel = 1'b0;
    #1;
  endtask

  function automatic int pend_off(input int l);
    return (l == 2) ? 8 : 4;
  endfunction

  function automatic int en_off(input int l);
    return (l == 0) ? 8 : ((l == 1) ? 52 : 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r [3];
    logic [31:0] exp_ctrl [3];
    logic        exp_en [3];
    rst_n = 1'b0; nmi = 1'b1; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state of every copy
    for (int l = 0; l < 3; l++) begin
      rd(8'h00, r[0], r[1], r[2]);  chk(r[l], 32'h0, "R1");
      rd(AW'(pend_off(l)), r[0], r[1], r[2]); chk(r[l], 32'h0, "R1");
      rd(AW'(en_off(l)), r[0], r[1], r[2]);   chk(r[l], 32'h0, "R1");
      chk({31'b0, irq[l]}, 32'h0, "R1");
      exp_ctrl[l] = 32'h0; exp_en[l] = 1'b0;
    end

    // R10 / R11 / R2: decode sweep over all word offsets, all layouts
    for (int o = 0; o < 16; o++) begin
      logic [31:0] v;
      v = 32'h3C5A_0001 | (32'(o) << 12) | (32'(o & 1) << 1);
      wr(AW'(o * 4), v);
      for (int l = 0; l < 3; l++) begin
        if (o * 4 == 0) exp_ctrl[l] = v;
        if (o * 4 == en_off(l)) exp_en[l] = v[0];
      end
      for (int a = 0; a < 16; a++) begin
        rd(AW'(a * 4), r[0], r[1], r[2]);
        for (int l = 0; l < 3; l++) begin
          if (a == 0)                    chk(r[l], exp_ctrl[l], "R2");
          else if (a * 4 == pend_off(l)) chk(r[l], 32'h0, "R10");
          else if (a * 4 == en_off(l))   chk(r[l], {31'b0, exp_en[l]}, "R10");
          else                           chk(r[l], 32'h0, "R11");
        end
      end
    end

    // Trigger-mode sweep on the default layout copy
    for (int m = 0; m < 4; m++) begin
      logic pol, edg;
      string t;
      pol = (m >= 2);
      edg = (m % 2 == 1);
      case (m)
        0: t = "R3";
        1: t = "R5";
        2: t = "R4";
        default: t = "R6";
      endcase
      nmi = ~pol;
      step(4);
      wr(8'h00, 32'hC0DE_0000 | 32'(m));
      rd(8'h00, r[0], r[1], r[2]); chk(r[0], 32'hC0DE_0000 | 32'(m), "R2");
      step(4);
      wr(8'h04, 32'h1);
      step(1);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h0, t);
      wr(8'h08, 32'h1);
      nmi = pol;
      step(2);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h0, t);
      step(1);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h1, t);
      chk({31'b0, irq[0]}, 32'h0, "R9");
      step(1);
      chk({31'b0, irq[0]}, 32'h1, "R9");
      wr(8'h04, 32'hFFFF_FFFE);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h1, "R7");
      wr(8'h08, 32'h0);
      step(1);
      chk({31'b0, irq[0]}, 32'h0, "R9");
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h1, "R9");
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, r[0], r[1], r[2]); chk(r[0], 32'h1, "R9");
      wr(8'h04, 32'h1);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], edg ? 32'h0 : 32'h1, edg ? t : "R8");
      step(3);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], edg ? 32'h0 : 32'h1, t);
      nmi = ~pol;
      step(4);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], edg ? 32'h0 : 32'h1, t);
      wr(8'h04, 32'h1);
      rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h0, "R7");
      step(1);
      chk({31'b0, irq[0]}, 32'h0, "R9");
      if (edg) begin
        nmi = pol;
        step(1);
        nmi = ~pol;
        step(4);
        rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h1, t);
        wr(8'h04, 32'h1);
        rd(8'h04, r[0], r[1], r[2]); chk(r[0], 32'h0, t);
      end
    end

    // R11: no read selected gives zero
    sel = 1'b0; we = 1'b0; addr = 8'h00;
    #2;
    chk(rdat[0], 32'h0, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule